// File: doc/BRIEF.md
# Chess Move Destination Finder

This block takes a full chessboard and the colour whose turn it is, and marks every square that some piece of that colour can move to or capture on. Each move must follow the basic movement rule of the piece that makes it. The board is held as 64 identical square cells. A cell that holds a piece of the side to move sends signals out in that piece's movement pattern. Signals from rooks, bishops and queens keep travelling through empty cells along their ray. Signals from knights, kings and pawns reach only their fixed neighbour offsets. A cell flags itself as a destination when a matching signal reaches it and it does not hold a piece of the moving side.

The search logic runs in the next cycle and uses the result as the set of candidate destination squares. The block does not check whether a piece is pinned or whether the king is left in check. The whole board is evaluated in one combinational pass. The 64-bit result is captured in a register on each rising clock edge.

Top module: `sqgrid_victim`

## Requirements
- R1: While rst_ni is low, victim_o is all zeros. Otherwise victim_o shows the result for the board_i and side_i sampled at the previous rising edge of clk_i.
- R2: Square s = rank*8 + file, with index 0 at the lower-left corner (a1) and rank 0 as white's home rank. Square s occupies board_i[4*s+3:4*s]. Bit 3 of a code is the colour (0 white, 1 black); side_i uses the same coding. Bits 2:0 give the type: 0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king, 7 inert. An inert piece blocks rays and moves nowhere.
- R3: A square that holds a piece of the side to move is never flagged.
- R4: A rook or queen flags each square along the four orthogonal rays, up to and including the first occupied square. That first occupied square is flagged only when it holds an enemy piece.
- R5: A bishop or queen does the same along the four diagonal rays.
- R6: A knight flags the up-to-eight squares at offsets (±1,±2) and (±2,±1) in file and rank.
- R7: A king flags the up-to-eight adjacent squares.
- R8: A pawn moves forward one rank: +1 for white, −1 for black. It flags the square straight ahead only when that square is empty. It flags the two forward-diagonal squares only when they hold enemy pieces.
- R9: No move pattern wraps from one board edge to the opposite edge.
- R10: Any piece, of either colour and including an inert one, stops a ray. Squares beyond it are not flagged by that ray.
- R11: Pieces of the side not on move have no effect except as blockers and capture targets. A board with no piece of the side to move gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| board_i | input | 256 | 64 four-bit piece codes, square s at bits 4s+3..4s |
| side_i | input | 1 | Side to move, 0 white, 1 black |
| victim_o | output | 64 | Registered destination flags, bit s for square s |

## Verification
Pieces are placed on corner and edge squares, such as a knight on a1 and on h8, a bishop on a1 and a queen on h1. A design that lets signals wrap across an edge would flag squares on the opposite file or rank. Rays are blocked by friendly, enemy and inert pieces. A wrong stop rule would either flag the friendly blocker or leak flags past the blocker. Pawns of both colours face an occupied square straight ahead and empty diagonals. A design that mixes up the push and capture conditions would flag the blocked square or the empty diagonals. The same board is evaluated with each side to move, so any leakage of the idle side's patterns appears as extra flags.

// File: rtl/sqgrid_pkg.sv
package sqgrid_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    PC_NONE   = 3'd0,
    PC_PAWN   = 3'd1,
    PC_KNIGHT = 3'd2,
    PC_BISHOP = 3'd3,
    PC_ROOK   = 3'd4,
    PC_QUEEN  = 3'd5,
    PC_KING   = 3'd6,
    PC_INERT  = 3'd7
  } piece_e;

  // directions 0..3 orthogonal, 4..7 diagonal
  function automatic int dir_df(input int d);
    case (d)
      0, 4, 6: return 1;
      1, 5, 7: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int dir_dr(input int d);
    case (d)
      2, 4, 5: return 1;
      3, 6, 7: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int kn_df(input int k);
    case (k)
      0, 3:    return 1;
      1, 2:    return 2;
      4, 7:    return -1;
      default: return -2;
    endcase
  endfunction

  function automatic int kn_dr(input int k);
    case (k)
      0, 7:    return 2;
      1, 6:    return 1;
      2, 5:    return -1;
      default: return -2;
    endcase
  endfunction
endpackage

// File: rtl/sqgrid_cell.sv
module sqgrid_cell
  import sqgrid_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              side_i,
  input  logic              ray_hit_i,
  input  logic              leap_hit_i,
  input  logic              pawn_push_i,
  input  logic              pawn_cap_i,
  output logic              empty_o,
  output logic              ortho_o,
  output logic              diag_o,
  output logic              knight_o,
  output logic              king_o,
  output logic              pawn_o,
  output logic              victim_o
);
  piece_e kind;
  logic   own, enemy;

  always_comb begin
    kind     = piece_e'(code_i[2:0]);
    empty_o  = (kind == PC_NONE);
    own      = !empty_o && (code_i[3] == side_i);
    enemy    = !empty_o && !own;
    ortho_o  = own && (kind == PC_ROOK || kind == PC_QUEEN);
    diag_o   = own && (kind == PC_BISHOP || kind == PC_QUEEN);
    knight_o = own && (kind == PC_KNIGHT);
    king_o   = own && (kind == PC_KING);
    pawn_o   = own && (kind == PC_PAWN);
    victim_o = !own && (ray_hit_i || leap_hit_i ||
                        (pawn_push_i && empty_o) || (pawn_cap_i && enemy));
  end
endmodule

// File: rtl/sqgrid_ray.sv
module sqgrid_ray #(
  parameter int EDGE = 8,
  parameter int DF   = 1,
  parameter int DR   = 0,
  localparam int NSQ = EDGE * EDGE
) (
  input  logic [NSQ-1:0] src_i,
  input  logic [NSQ-1:0] empty_i,
  output logic [NSQ-1:0] reach_o
);
  localparam int OFF = DR * EDGE + DF;

  logic [NSQ-1:0] acc;

  // walk squares so the upstream neighbour is always resolved first
  always_comb begin
    acc = '0;
    for (int i = 0; i < NSQ; i++) begin
      int s, pf, pr, p;
      s  = (OFF > 0) ? i : NSQ - 1 - i;
      pf = (s % EDGE) - DF;
      pr = (s / EDGE) - DR;
      if (pf >= 0 && pf < EDGE && pr >= 0 && pr < EDGE) begin
        p      = pr * EDGE + pf;
        acc[s] = src_i[p] | (empty_i[p] & acc[p]);
      end
    end
  end

  assign reach_o = acc;
endmodule

// File: rtl/sqgrid_step.sv
module sqgrid_step
  import sqgrid_pkg::*;
#(
  parameter int EDGE = 8,
  localparam int NSQ = EDGE * EDGE
) (
  input  logic [NSQ-1:0] knight_i,
  input  logic [NSQ-1:0] king_i,
  input  logic [NSQ-1:0] pawn_i,
  input  logic           side_i,
  output logic [NSQ-1:0] leap_o,
  output logic [NSQ-1:0] push_o,
  output logic [NSQ-1:0] cap_o
);
  always_comb begin
    leap_o = '0;
    push_o = '0;
    cap_o  = '0;
    for (int s = 0; s < NSQ; s++) begin
      int f, r, sf, sr, fwd;
      f = s % EDGE;
      r = s / EDGE;
      for (int k = 0; k < 8; k++) begin
        sf = f - kn_df(k);
        sr = r - kn_dr(k);
        if (sf >= 0 && sf < EDGE && sr >= 0 && sr < EDGE && knight_i[sr*EDGE+sf])
          leap_o[s] = 1'b1;
        sf = f - dir_df(k);
        sr = r - dir_dr(k);
        if (sf >= 0 && sf < EDGE && sr >= 0 && sr < EDGE && king_i[sr*EDGE+sf])
          leap_o[s] = 1'b1;
      end
      fwd = side_i ? -1 : 1;
      sr  = r - fwd;
      if (sr >= 0 && sr < EDGE) begin
        if (pawn_i[sr*EDGE+f]) push_o[s] = 1'b1;
        if (f > 0 && pawn_i[sr*EDGE+f-1]) cap_o[s] = 1'b1;
        if (f < EDGE - 1 && pawn_i[sr*EDGE+f+1]) cap_o[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sqgrid_victim.sv
module sqgrid_victim
  import sqgrid_pkg::*;
#(
  parameter int EDGE = 8,
  localparam int NSQ = EDGE * EDGE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSQ*CODE_W-1:0] board_i,
  input  logic                  side_i,
  output logic [NSQ-1:0]        victim_o
);
  localparam int NDIR = 8;

  logic [NSQ-1:0] empty_v, ortho_v, diag_v, knight_v, king_v, pawn_v;
  logic [NSQ-1:0] leap_v, push_v, cap_v, ray_v, victim_d;
  logic [NSQ-1:0] reach [NDIR];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    if (d < 4) begin : g_ortho
      sqgrid_ray #(.EDGE(EDGE), .DF(dir_df(d)), .DR(dir_dr(d))) u_ray (
        .src_i(ortho_v), .empty_i(empty_v), .reach_o(reach[d]));
    end else begin : g_diag
      sqgrid_ray #(.EDGE(EDGE), .DF(dir_df(d)), .DR(dir_dr(d))) u_ray (
        .src_i(diag_v), .empty_i(empty_v), .reach_o(reach[d]));
    end
  end

  always_comb begin
    ray_v = '0;
    for (int d = 0; d < NDIR; d++) ray_v |= reach[d];
  end

  sqgrid_step #(.EDGE(EDGE)) u_step (
    .knight_i(knight_v), .king_i(king_v), .pawn_i(pawn_v), .side_i(side_i),
    .leap_o(leap_v), .push_o(push_v), .cap_o(cap_v));

  for (genvar s = 0; s < NSQ; s++) begin : g_sq
    sqgrid_cell u_cell (
      .code_i     (board_i[s*CODE_W +: CODE_W]),
      .side_i     (side_i),
      .ray_hit_i  (ray_v[s]),
      .leap_hit_i (leap_v[s]),
      .pawn_push_i(push_v[s]),
      .pawn_cap_i (cap_v[s]),
      .empty_o    (empty_v[s]),
      .ortho_o    (ortho_v[s]),
      .diag_o     (diag_v[s]),
      .knight_o   (knight_v[s]),
      .king_o     (king_v[s]),
      .pawn_o     (pawn_v[s]),
      .victim_o   (victim_d[s]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) victim_o <= '0;
    else         victim_o <= victim_d;
  end

  // checks derived straight from the board encoding
  logic [NSQ-1:0] own_chk;
  always_comb begin
    for (int s = 0; s < NSQ; s++)
      own_chk[s] = (board_i[s*CODE_W +: 3] != 3'd0) && (board_i[s*CODE_W+3] == side_i);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R1: assert (victim_o == '0);
  end

  assert_no_own_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (victim_o & $past(own_chk)) == '0);

  assert_idle_side_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_chk == '0) |=> (victim_o == '0));

  assert_hold_when_static_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(board_i) && $stable(side_i)) |=> $stable(victim_o));
endmodule

// File: tb/sqgrid_victim_test.sv
module sqgrid_victim_test;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] brd = '0;
  logic         side = 1'b0;
  logic [63:0]  victim;
  logic [63:0]  exp_m;
  int           nchk = 0;
  int           nerr = 0;
  bit           done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sqgrid_victim uut (.clk_i(clk), .rst_ni(rst_n), .board_i(brd), .side_i(side), .victim_o(victim));

  task automatic put(input int sq, input logic [3:0] code);
    brd[sq*4 +: 4] = code;
  endtask

  task automatic clear();
    brd   = '0;
    exp_m = '0;
  endtask

  task automatic evaluate(input string req, input logic [63:0] exp_v);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    nchk++;
    if (victim !== exp_v) begin
      nerr++;
      $display("FAIL %s: victim=%h expected=%h", req, victim, exp_v);
    end
    nchk++;
    if ($countones(victim) != $countones(exp_v)) begin
      nerr++;
      $display("FAIL %s count: got %0d expected %0d", req, $countones(victim), $countones(exp_v));
    end
  endtask

  task automatic t_reset();  // R1
    nchk++;
    if (victim !== '0) begin
      nerr++;
      $display("FAIL R1 reset: victim=%h expected=0", victim);
    end
  endtask

  task automatic t_rook();  // R4: rook d4 on empty board
    clear(); side = 0;
    put(27, 4'h4);
    for (int s = 0; s < 64; s++) if ((s % 8 == 3 || s / 8 == 3) && s != 27) exp_m[s] = 1;
    evaluate("R4 rook", exp_m);
  endtask

  task automatic t_bishop();  // R5 R9: bishop a1
    clear(); side = 0;
    put(0, 4'h3);
    for (int i = 1; i < 8; i++) exp_m[i*9] = 1;
    evaluate("R5_R9 bishop", exp_m);
  endtask

  task automatic t_queen_block();  // R4 R5 R10 R8: queen h1, own pawn h2, enemy knight g2
    clear(); side = 0;
    put(7, 4'h5); put(15, 4'h1); put(14, 4'hA);
    for (int i = 0; i < 7; i++) exp_m[i] = 1;
    exp_m[14] = 1; exp_m[23] = 1;
    evaluate("R10 queen blocked", exp_m);
  endtask

  task automatic t_knight();  // R6 R9: knights a1 and h8
    clear(); side = 0;
    put(0, 4'h2); put(63, 4'h2);
    exp_m[17] = 1; exp_m[10] = 1; exp_m[46] = 1; exp_m[53] = 1;
    evaluate("R6_R9 knight", exp_m);
  endtask

  task automatic t_kings();  // R7 R11 R3: both sides on one board
    clear();
    put(4, 4'h6); put(56, 4'hE); put(49, 4'h4);
    side = 1;
    exp_m[57] = 1; exp_m[48] = 1; exp_m[49] = 1;
    evaluate("R7_R11 black king", exp_m);
    exp_m = '0; side = 0;
    exp_m[3] = 1; exp_m[5] = 1; exp_m[11] = 1; exp_m[12] = 1; exp_m[13] = 1;
    exp_m[57] = 1; exp_m[41] = 1; exp_m[33] = 1; exp_m[25] = 1; exp_m[17] = 1; exp_m[9] = 1;
    exp_m[1] = 1; exp_m[48] = 1;
    for (int i = 50; i < 56; i++) exp_m[i] = 1;
    evaluate("R7_R3 white king rook", exp_m);
  endtask

  task automatic t_pawns();  // R8: black pawns
    clear(); side = 1;
    put(52, 4'h9); put(43, 4'h2); put(32, 4'h9); put(24, 4'h1);
    exp_m[44] = 1; exp_m[43] = 1;
    evaluate("R8 black pawns", exp_m);
  endtask

  task automatic t_no_own();  // R11 R2 R10: idle-side pieces and inert blocker
    clear(); side = 0;
    put(27, 4'hC); put(10, 4'hD); put(40, 4'hA);
    evaluate("R11 no own pieces", exp_m);
    clear(); side = 0;
    put(3, 4'h4); put(27, 4'h7);
    exp_m[0] = 1; exp_m[1] = 1; exp_m[2] = 1; exp_m[11] = 1; exp_m[19] = 1;
    for (int i = 4; i < 8; i++) exp_m[i] = 1;
    evaluate("R2_R10 inert blocker", exp_m);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: expired expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    put(27, 4'h4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_rook();
    t_bishop();
    t_queen_block();
    t_knight();
    t_kings();
    t_pawns();
    t_no_own();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule